// File: doc/BRIEF.md
# Label-Filtered Receive Word Buffer

This block is the acceptance and storage stage of one serial avionics receive channel. The bit decoder ahead of it hands over a finished 32-bit word with a one-cycle end-of-word strobe. The block then applies two filters. The first is a lookup of the word's 8-bit label in a 16-entry table. The second is a check of two fixed-position word bits against a programmed pattern. Each filter can be switched on or off. A word that passes every enabled filter is written into a four-word FIFO.

The host side reads the oldest word through a pop strobe. The head word is presented combinationally, with the label byte arranged in either of two bit orders. The block reports empty and full status and drives an attention flag. The flag can be set to mean either "data waiting" or "buffer full". The command decoder loads and reads back the label table as a stream of bytes. A channel-clear control flushes the buffer and holds the channel idle for as long as it stays high.

Top module: `rxw_label_fifo`

## Requirements
- R1: With `cfg_label_en`=0, every word strobed by `eos_valid` is stored, whatever its label, provided the pattern check (R3) passes or is off.
- R2: With `cfg_label_en`=1, a word is stored only if its label equals one of the 16 table bytes. The label is built from word bits 0..7, with bit 0 as the label MSB and bit 7 as the LSB. The value 0x00 matches like any other value.
- R3: With `cfg_decode_en`=1, a word is stored only if word bit 9 equals `cfg_want_b10` and word bit 8 equals `cfg_want_b9`. When both this check and R2 are enabled, both must pass.
- R4: Stored words leave in arrival order, up to 4 words. `fifo_empty` is high when no words are held. `fifo_full` is high when 4 words are held. `pop_word` shows the oldest word, and `pop` removes it.
- R5: When a word is accepted while 4 words are held and no pop occurs in that cycle, it replaces the most recently stored word. The count stays at 4.
- R6: `chan_flag` equals `!fifo_empty` when `cfg_flag_on_full`=0, and equals `fifo_full` when `cfg_flag_on_full`=1.
- R7: While `cfg_chan_clr`=1, the FIFO is emptied on the next clock edge, and strobed words and pops have no effect.
- R8: `pop_word[31:8]` equals word bits 31..8. With `cfg_label_as_rx`=1, `pop_word[7-i]` equals word bit i, so the label is in receive order with its MSB at bit 7. With `cfg_label_as_rx`=0, `pop_word[7:0]` equals word bits 7..0.
- R9: A pop while empty returns `pop_word`=0 and changes nothing. A pop and an accepted word in the same cycle are both carried out. A full buffer then stays full with the old head removed, and an empty buffer then holds just the new word.
- R10: A byte on `lbl_wr_valid` with `lbl_wr_first`=1 is written to entry 0. Each further write goes to the next entry, wrapping after entry 15. `lbl_rd_first` points the read-back at entry 0, and `lbl_rd_next` advances it with the same wrap. `lbl_rd_byte` shows the addressed entry one cycle later.
- R11: After `rst_n` is asserted, the FIFO is empty, `chan_flag` is low, `pop_word` is 0, and all table entries read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flag_on_full | input | 1 | Flag meaning: 0 not-empty, 1 full |
| cfg_label_en | input | 1 | Enable label table filter |
| cfg_chan_clr | input | 1 | Clear and hold the channel idle |
| cfg_decode_en | input | 1 | Enable bit 9/8 pattern filter |
| cfg_want_b10 | input | 1 | Required value of word bit 9 |
| cfg_want_b9 | input | 1 | Required value of word bit 8 |
| cfg_label_as_rx | input | 1 | Output label in receive order |
| eos_valid | input | 1 | Completed word strobe |
| eos_word | input | 32 | Completed word, bit i = i-th bit received |
| lbl_wr_valid | input | 1 | Label byte write strobe |
| lbl_wr_first | input | 1 | This write targets entry 0 |
| lbl_wr_byte | input | 8 | Label byte to write |
| lbl_rd_first | input | 1 | Point read-back at entry 0 |
| lbl_rd_next | input | 1 | Advance read-back pointer |
| lbl_rd_byte | output | 8 | Entry at read-back pointer |
| pop | input | 1 | Remove the head word |
| pop_word | output | 32 | Head word in output order, 0 when empty |
| fifo_empty | output | 1 | No words held |
| fifo_full | output | 1 | Four words held |
| chan_flag | output | 1 | Attention flag per R6 |

## Verification
The first set of cases feeds word streams under each filter setting: all filters off, labels only, pattern only, and both. Each set mixes words that differ in just one label bit or in just one of bits 9 and 8, so the bench can tell which filter rejected a word and whether the two filters are combined as a conjunction. Bursts of five or more accepted words separate overwrite-newest from drop-newest and overwrite-oldest behaviour. Pops issued while empty, while full, and together with an accepted word probe the count arithmetic at both ends. Label streams that run past entry 15 expose wrap errors, and a table holding 0x00 checks that zero is not treated as an unused entry.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int WORD_W  = 32;
  localparam int LBL_W   = 8;
  localparam int ENTRIES = 16;
  localparam int DEPTH   = 4;
  // positions of the two pattern bits inside the received word
  localparam int PAT_HI  = 9;
  localparam int PAT_LO  = 8;

  typedef struct packed {
    logic label_en;
    logic decode_en;
    logic want_hi;
    logic want_lo;
  } filt_cfg_t;
endpackage

// File: rtl/rxw_label_table.sv
module rxw_label_table #(
  parameter int ENTRIES = 16,
  parameter int LBL_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_first,
  input  logic [LBL_W-1:0] wr_byte,
  input  logic             rd_first,
  input  logic             rd_next,
  output logic [LBL_W-1:0] rd_byte,
  input  logic [LBL_W-1:0] probe,
  output logic             hit
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [LBL_W-1:0] tbl_q [ENTRIES];
  logic [IW-1:0]    wr_idx_q, wr_idx_n, wr_sel;
  logic [IW-1:0]    rd_idx_q, rd_idx_n;
  logic [ENTRIES-1:0] hit_vec;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    wr_sel   = wr_first ? '0 : wr_idx_q;
    wr_idx_n = wr_idx_q;
    if (wr_valid) wr_idx_n = wrap_inc(wr_sel);
    rd_idx_n = rd_idx_q;
    if (rd_first)     rd_idx_n = '0;
    else if (rd_next) rd_idx_n = wrap_inc(rd_idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
    end else begin
      wr_idx_q <= wr_idx_n;
      rd_idx_q <= rd_idx_n;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  tbl_q[g] <= '0;
        else if (wr_valid && (wr_sel == IW'(g)))     tbl_q[g] <= wr_byte;
      end
      assign hit_vec[g] = (tbl_q[g] == probe);
    end
  endgenerate

  assign hit     = |hit_vec;
  assign rd_byte = tbl_q[rd_idx_q];
endmodule

// File: rtl/rxw_word_filter.sv
module rxw_word_filter
  import rxw_pkg::*;
(
  input  filt_cfg_t cfg,
  input  logic      strobe,
  input  logic      hold,
  input  logic      label_hit,
  input  logic      bit_hi,
  input  logic      bit_lo,
  output logic      accept
);
  logic label_ok, pat_ok;

  always_comb begin
    label_ok = !cfg.label_en || label_hit;
    pat_ok   = !cfg.decode_en || ((bit_hi == cfg.want_hi) && (bit_lo == cfg.want_lo));
    accept   = strobe && !hold && label_ok && pat_ok;
  end
endmodule

// File: rtl/rxw_word_fifo.sv
module rxw_word_fifo #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n, waddr;
  logic [CW-1:0] cnt_q, cnt_n;
  logic do_pop, do_push, ovw, push_new, we;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] v);
    return (v == LASTP) ? '0 : v + 1'b1;
  endfunction
  function automatic logic [AW-1:0] dec(input logic [AW-1:0] v);
    return (v == '0) ? LASTP : v - 1'b1;
  endfunction

  always_comb begin
    do_pop   = pop && !clr && (cnt_q != '0);
    do_push  = push && !clr;
    ovw      = do_push && !do_pop && (cnt_q == FULLC);
    push_new = do_push && !ovw;
    we       = do_push;
    waddr    = ovw ? dec(wr_q) : wr_q;
    wr_n     = wr_q;
    rd_n     = rd_q;
    cnt_n    = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push_new) wr_n = inc(wr_q);
      if (do_pop)   rd_n = inc(rd_q);
      case ({push_new, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULLC);
  assign head  = empty ? '0 : mem_q[rd_q];

  // R4
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n) !(empty && full));
  // R4
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> !empty);
  // R5
  ovw_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  // R9
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  // R7
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/rxw_label_fifo.sv
module rxw_label_fifo
  import rxw_pkg::*;
#(
  parameter int W_WORD  = WORD_W,
  parameter int W_LBL   = LBL_W,
  parameter int N_LBL   = ENTRIES,
  parameter int N_DEPTH = DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_flag_on_full,
  input  logic              cfg_label_en,
  input  logic              cfg_chan_clr,
  input  logic              cfg_decode_en,
  input  logic              cfg_want_b10,
  input  logic              cfg_want_b9,
  input  logic              cfg_label_as_rx,
  input  logic              eos_valid,
  input  logic [W_WORD-1:0] eos_word,
  input  logic              lbl_wr_valid,
  input  logic              lbl_wr_first,
  input  logic [W_LBL-1:0]  lbl_wr_byte,
  input  logic              lbl_rd_first,
  input  logic              lbl_rd_next,
  output logic [W_LBL-1:0]  lbl_rd_byte,
  input  logic              pop,
  output logic [W_WORD-1:0] pop_word,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              chan_flag
);
  logic [W_LBL-1:0]  rx_label, head_label;
  logic [W_WORD-1:0] head;
  logic              hit, accept;
  filt_cfg_t         fcfg;

  genvar i;
  generate
    for (i = 0; i < W_LBL; i++) begin : g_lbl
      assign rx_label[W_LBL-1-i]   = eos_word[i];
      assign head_label[W_LBL-1-i] = head[i];
    end
  endgenerate

  assign fcfg = '{label_en: cfg_label_en, decode_en: cfg_decode_en,
                  want_hi: cfg_want_b10, want_lo: cfg_want_b9};

  rxw_label_table #(.ENTRIES(N_LBL), .LBL_W(W_LBL)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (lbl_wr_valid),
    .wr_first (lbl_wr_first),
    .wr_byte  (lbl_wr_byte),
    .rd_first (lbl_rd_first),
    .rd_next  (lbl_rd_next),
    .rd_byte  (lbl_rd_byte),
    .probe    (rx_label),
    .hit      (hit)
  );

  rxw_word_filter u_filter (
    .cfg       (fcfg),
    .strobe    (eos_valid),
    .hold      (cfg_chan_clr),
    .label_hit (hit),
    .bit_hi    (eos_word[PAT_HI]),
    .bit_lo    (eos_word[PAT_LO]),
    .accept    (accept)
  );

  rxw_word_fifo #(.DEPTH(N_DEPTH), .WORD_W(W_WORD)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_chan_clr),
    .push  (accept),
    .wdata (eos_word),
    .pop   (pop),
    .head  (head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  always_comb begin
    pop_word = head;
    if (cfg_label_as_rx) pop_word[W_LBL-1:0] = head_label;
    chan_flag = cfg_flag_on_full ? fifo_full : !fifo_empty;
  end

  // R2
  lbl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && eos_valid && cfg_label_en && !hit && !pop) |=> fifo_empty);
  // R6
  flag_full_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flag_on_full && !fifo_full) |-> !chan_flag);
endmodule

// File: tb/tb_rxw_label_fifo.sv
module tb_rxw_label_fifo;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_flag_on_full, cfg_label_en, cfg_chan_clr, cfg_decode_en;
  logic cfg_want_b10, cfg_want_b9, cfg_label_as_rx;
  logic eos_valid;
  logic [31:0] eos_word;
  logic lbl_wr_valid, lbl_wr_first;
  logic [7:0] lbl_wr_byte;
  logic lbl_rd_first, lbl_rd_next;
  logic [7:0] lbl_rd_byte;
  logic pop;
  logic [31:0] pop_word;
  logic fifo_empty, fifo_full, chan_flag;

  always #(CLK_P/2) clk = ~clk;

  rxw_label_fifo dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R11";

  logic [31:0] q[$];
  logic [7:0]  tbl[16];
  int wr_idx = 0;
  int rd_idx = 0;

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(logic [31:0] w);
    logic [31:0] r = w;
    if (cfg_label_as_rx) for (int i = 0; i < 8; i++) r[7-i] = w[i];
    return r;
  endfunction

  function automatic logic [31:0] mk(logic [7:0] lbl, logic b10, logic b9, logic [21:0] d);
    logic [31:0] w;
    w[31:10] = d;
    w[9] = b10;
    w[8] = b9;
    for (int i = 0; i < 8; i++) w[i] = lbl[7-i];
    return w;
  endfunction

  task automatic compare();
    chk(tag, "empty", {31'd0, fifo_empty}, {31'd0, q.size() == 0});
    chk(tag, "full", {31'd0, fifo_full}, {31'd0, q.size() == 4});
    chk("R6", "flag", {31'd0, chan_flag},
        {31'd0, cfg_flag_on_full ? (q.size() == 4) : (q.size() != 0)});
    chk(tag, "pop_word", pop_word, (q.size() != 0) ? fmt(q[0]) : 32'd0);
    chk("R10", "lbl_rd_byte", {24'd0, lbl_rd_byte}, {24'd0, tbl[rd_idx]});
  endtask

  task automatic step();
    logic acc;
    logic [7:0] l;
    bit m;
    int idx;
    @(posedge clk);
    for (int i = 0; i < 8; i++) l[7-i] = eos_word[i];
    m = 0;
    for (int k = 0; k < 16; k++) if (tbl[k] == l) m = 1;
    acc = eos_valid && !cfg_chan_clr && (!cfg_label_en || m) &&
          (!cfg_decode_en || (eos_word[9] == cfg_want_b10 && eos_word[8] == cfg_want_b9));
    if (cfg_chan_clr) q.delete();
    else begin
      if (pop && q.size() != 0) void'(q.pop_front());
      if (acc) begin
        if (q.size() == 4) q[3] = eos_word;
        else q.push_back(eos_word);
      end
    end
    if (lbl_wr_valid) begin
      idx = lbl_wr_first ? 0 : wr_idx;
      tbl[idx] = lbl_wr_byte;
      wr_idx = (idx + 1) % 16;
    end
    if (lbl_rd_first) rd_idx = 0;
    else if (lbl_rd_next) rd_idx = (rd_idx + 1) % 16;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    eos_valid = 0; pop = 0; lbl_wr_valid = 0; lbl_wr_first = 0;
    lbl_rd_first = 0; lbl_rd_next = 0;
  endtask

  task automatic send(logic [31:0] w);
    eos_valid = 1; eos_word = w; step(); idle();
  endtask

  task automatic pop1();
    pop = 1; step(); idle();
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) pop1();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0;
    cfg_flag_on_full = 0; cfg_label_en = 0; cfg_chan_clr = 0; cfg_decode_en = 0;
    cfg_want_b10 = 0; cfg_want_b9 = 0; cfg_label_as_rx = 0;
    eos_word = '0; lbl_wr_byte = '0;
    idle();
    for (int k = 0; k < 16; k++) tbl[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "empty", {31'd0, fifo_empty}, 32'd1);
    chk("R11", "flag", {31'd0, chan_flag}, 32'd0);
    chk("R11", "pop_word", pop_word, 32'd0);
    chk("R11", "lbl_rd_byte", {24'd0, lbl_rd_byte}, 32'd0);
    rst_n = 1;
    step();

    // R1: no label filtering
    tag = "R1";
    send(mk(8'h11, 0, 0, 22'h1));
    send(mk(8'hA5, 1, 1, 22'h2));
    send(mk(8'h00, 1, 0, 22'h3));
    chk("R1", "three stored not full", {31'd0, fifo_full}, 32'd0);
    tag = "R4";
    drain();

    // R10: label stream write, wrap, read back
    tag = "R10";
    for (int k = 0; k < 18; k++) begin
      lbl_wr_valid = 1; lbl_wr_first = (k == 0);
      lbl_wr_byte = 8'h30 + 8'(k * 7);
      step();
    end
    idle();
    lbl_wr_valid = 1; lbl_wr_first = 1; lbl_wr_byte = 8'h00; step(); idle();
    lbl_rd_first = 1; step(); idle();
    chk("R10", "entry0 after rewrite", {24'd0, lbl_rd_byte}, 32'h00);
    for (int k = 0; k < 17; k++) begin lbl_rd_next = 1; step(); end
    idle();

    // R2: label filter on
    tag = "R2";
    cfg_label_en = 1;
    send(mk(8'h00, 0, 0, 22'h10));
    send(mk(8'h01, 0, 0, 22'h11));
    send(mk(tbl[5], 0, 0, 22'h12));
    send(mk(tbl[5] ^ 8'h80, 0, 0, 22'h13));
    send(mk(tbl[15], 1, 1, 22'h14));
    tag = "R4";
    drain();

    // R3: pattern filter, alone and combined
    tag = "R3";
    cfg_label_en = 0; cfg_decode_en = 1; cfg_want_b10 = 1; cfg_want_b9 = 0;
    send(mk(8'h01, 1, 0, 22'h20));
    send(mk(8'h01, 0, 0, 22'h21));
    send(mk(8'h01, 1, 1, 22'h22));
    cfg_label_en = 1;
    send(mk(tbl[3], 1, 0, 22'h23));
    send(mk(tbl[3], 0, 1, 22'h24));
    send(mk(8'h01, 1, 0, 22'h25));
    chk("R3", "two accepted not full", {31'd0, fifo_full}, 32'd0);
    tag = "R4";
    drain();
    cfg_label_en = 0; cfg_decode_en = 0;

    // R4/R5: fill then overwrite newest
    tag = "R5";
    for (int k = 0; k < 6; k++) send(mk(8'h40 + 8'(k), 0, 0, 22'h100 + 22'(k)));
    chk("R5", "still full", {31'd0, fifo_full}, 32'd1);
    tag = "R4";
    drain();

    // R6: flag modes
    tag = "R6";
    cfg_flag_on_full = 1;
    for (int k = 0; k < 4; k++) send(mk(8'h50, 0, 0, 22'(k)));
    chk("R6", "flag on full", {31'd0, chan_flag}, 32'd1);
    pop1();
    chk("R6", "flag after pop", {31'd0, chan_flag}, 32'd0);
    cfg_flag_on_full = 0; step();

    // R8: label order on output
    tag = "R8";
    cfg_label_as_rx = 1; step();
    chk("R8", "rx order head", {24'd0, pop_word[7:0]}, {24'd0, 8'h50});
    cfg_label_as_rx = 0; step();

    // R7: channel clear holds
    tag = "R7";
    cfg_chan_clr = 1; step();
    send(mk(8'h60, 0, 0, 22'h7));
    pop1();
    chk("R7", "empty in clear", {31'd0, fifo_empty}, 32'd1);
    cfg_chan_clr = 0; step();
    send(mk(8'h61, 0, 0, 22'h8));
    chk("R7", "resumes", {31'd0, fifo_empty}, 32'd0);
    tag = "R4";
    drain();

    // R9: pop on empty, pop+push at both ends
    tag = "R9";
    pop1();
    chk("R9", "empty pop zero", pop_word, 32'd0);
    eos_valid = 1; pop = 1; eos_word = mk(8'h70, 0, 0, 22'h9); step(); idle();
    for (int k = 0; k < 3; k++) send(mk(8'h71, 0, 0, 22'(k)));
    eos_valid = 1; pop = 1; eos_word = mk(8'h72, 1, 1, 22'hA); step(); idle();
    chk("R9", "full kept", {31'd0, fifo_full}, 32'd1);
    tag = "R4";
    drain();

    finish_run();
  end
endmodule